// File: doc/BRIEF.md
# Bus Interrupt Status and Aggregation Hub

This block keeps the interrupt state of a group of serial-bus engines. Each bus has an event-status register, an enable mask and a level interrupt line. A summary vector, one bit per bus, shows which buses hold a pending interrupt. The bus sequencers report events as single-cycle pulses, one pulse vector per bus. Software programs the mask, reads the status, and clears status bits by writing ones.

The mask is applied when events are raised, not when the status is read. A disabled event is dropped on arrival. Any earlier bit whose enable has since been removed is also dropped when the next event for that bus is raised. If software clears a latched receive-complete bit while that bus still has a receive command outstanding, the hub emits a one-cycle restart pulse to the sequencer and re-evaluates the status against the mask in the same cycle.

Register access uses a simple write strobe, with a bus index and a register selector, and a combinational read port. A state change becomes visible one clock after the write or event cycle.

Top module: `irqhub_top`

## Requirements
- R1: After reset, every status register, enable mask, summary bit, interrupt line and restart pulse is zero.
- R2: A write with selector 0 loads the addressed bus's enable mask with data bits 14:0. Bit 15 of the mask always reads 0.
- R3: The event bit positions are: 0 transmit-acked, 1 transmit-nacked, 2 receive-done, 3 arbitration lost, 4 normal stop, 5 abnormal stop, 6 clock-low timeout, 13 recovery done, 14 data-low timeout, 15 target inactive. An event pulse on an enabled position sets that status bit from the next cycle. A pulse on a disabled position is not latched. Pulses on positions 7 to 12 are ignored completely. Bit 15 can never latch.
- R4: In a cycle where at least one event is raised for a bus, all status bits of that bus whose enable bit is 0 are dropped, including bits that latched earlier.
- R5: When raising leaves the status nonzero, the bus interrupt line and its summary bit go high on the next cycle.
- R6: A write with selector 1 clears every status bit in 14:0 for which the data bit is 1, and leaves the other bits unchanged.
- R7: The interrupt line and summary bit fall only when a status write leaves that bus's status all zero. If raising leaves the status zero, the line keeps its value.
- R8: An event and a clear of the same bit in the same cycle leave the bit set, provided the bit is enabled.
- R9: If a status write clears receive-done (bit 2) while that bit is set and the bus's receive-pending input is high, the restart output for that bus pulses for one cycle on the next cycle, and the masking of R4 is applied in the write cycle. In every other case the restart output stays low.
- R10: Selector 2 reads the summary vector, zero-extended. Writes with selector 2 or 3 change no state. Selector 3 reads 0.
- R11: Writes that address a bus index of NBUS or above are ignored. Reads of such an index return 0.
- R12: Events, writes and interrupt state of one bus do not affect any other bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtIn | input | NBUS*16 | Event pulses, bus b in bits 16b+15:16b |
| rxCmdPending | input | NBUS | Receive command still outstanding, per bus |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Write selector: 0 enable, 1 status, 2 summary, 3 none |
| wrBus | input | BUS_W | Bus index of the write |
| wrData | input | 16 | Write data |
| rdSel | input | 2 | Read selector, same encoding as wrSel |
| rdBus | input | BUS_W | Bus index of the read |
| rdData | output | RD_W | Combinational read data |
| irq | output | NBUS | Level interrupt per bus |
| rxRestart | output | NBUS | One-cycle receive restart request per bus |

## Verification
The bench builds the hub with NBUS = 5, so the bus index is 3 bits wide and the indices 5 to 7 exist on the ports but name no bus. This makes the ignored writes and zero reads of R11 observable. It also gives the summary read a zero-extended upper part. Five buses are enough to run random events and writes on several buses at once while every register of every bus is compared each cycle.

// File: rtl/irqhub_pkg.sv
package irqhub_pkg;
  localparam int REG_W = 16;
  localparam logic [REG_W-1:0] EVT_VALID = 16'hE07F;
  localparam logic [REG_W-1:0] EN_KEEP   = 16'h7FFF;
  localparam logic [REG_W-1:0] CLR_KEEP  = 16'h7FFF;
  localparam int RXDONE_BIT = 2;

  localparam logic [1:0] SEL_ENABLE  = 2'd0;
  localparam logic [1:0] SEL_STATUS  = 2'd1;
  localparam logic [1:0] SEL_SUMMARY = 2'd2;

  typedef struct packed {
    logic             enWr;
    logic             stsWr;
    logic [REG_W-1:0] data;
  } busStrobe_t;
endpackage

// File: rtl/irqhub_ctrl.sv
module irqhub_ctrl
  import irqhub_pkg::*;
#(
  parameter int NBUS  = 16,
  parameter int BUS_W = 4,
  parameter int RD_W  = 32
) (
  input  logic                  wrEn,
  input  logic [1:0]            wrSel,
  input  logic [BUS_W-1:0]      wrBus,
  input  logic [REG_W-1:0]      wrData,
  input  logic [1:0]            rdSel,
  input  logic [BUS_W-1:0]      rdBus,
  input  logic [NBUS*REG_W-1:0] stsFlat,
  input  logic [NBUS*REG_W-1:0] enFlat,
  input  logic [NBUS-1:0]       sumVec,
  output busStrobe_t [NBUS-1:0] strobes,
  output logic [RD_W-1:0]       rdData
);
  // write decode: one strobe set per existing bus, unknown indices match none
  always_comb begin
    for (int b = 0; b < NBUS; b++) begin
      strobes[b].data  = wrData;
      strobes[b].enWr  = wrEn && (wrBus == BUS_W'(b)) && (wrSel == SEL_ENABLE);
      strobes[b].stsWr = wrEn && (wrBus == BUS_W'(b)) && (wrSel == SEL_STATUS);
    end
  end

  // read mux
  always_comb begin
    rdData = '0;
    if (rdSel == SEL_SUMMARY) begin
      rdData = RD_W'(sumVec);
    end else begin
      for (int b = 0; b < NBUS; b++) begin
        if (rdBus == BUS_W'(b)) begin
          if (rdSel == SEL_ENABLE)      rdData = RD_W'(enFlat[b*REG_W +: REG_W]);
          else if (rdSel == SEL_STATUS) rdData = RD_W'(stsFlat[b*REG_W +: REG_W]);
        end
      end
    end
  end
endmodule

// File: rtl/irqhub_bank.sv
module irqhub_bank
  import irqhub_pkg::*;
#(
  parameter int NBUS = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NBUS*REG_W-1:0] evtIn,
  input  logic [NBUS-1:0]       rxCmdPending,
  input  busStrobe_t [NBUS-1:0] strobes,
  output logic [NBUS*REG_W-1:0] stsFlat,
  output logic [NBUS*REG_W-1:0] enFlat,
  output logic [NBUS-1:0]       sumVec,
  output logic [NBUS-1:0]       rxRestart
);
  for (genvar b = 0; b < NBUS; b++) begin : g_bus
    logic [REG_W-1:0] stsQ, enQ, evt, clrMask, afterClr, merged, stsNext;
    logic anyEvt, rxHit, raise, sumQ, sumNext, restartQ;

    assign evt      = evtIn[b*REG_W +: REG_W] & EVT_VALID;
    assign anyEvt   = |evt;
    assign clrMask  = strobes[b].stsWr ? (strobes[b].data & CLR_KEEP) : '0;
    assign rxHit    = strobes[b].stsWr & strobes[b].data[RXDONE_BIT]
                    & stsQ[RXDONE_BIT] & rxCmdPending[b];
    assign afterClr = stsQ & ~clrMask;
    assign merged   = afterClr | evt;
    assign raise    = anyEvt | rxHit;
    assign stsNext  = raise ? (merged & enQ) : merged;

    always_comb begin
      sumNext = sumQ;
      if (raise && (stsNext != '0))                    sumNext = 1'b1;
      else if (strobes[b].stsWr && (stsNext == '0))    sumNext = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        stsQ     <= '0;
        enQ      <= '0;
        sumQ     <= 1'b0;
        restartQ <= 1'b0;
      end else begin
        stsQ     <= stsNext;
        sumQ     <= sumNext;
        restartQ <= rxHit;
        if (strobes[b].enWr) enQ <= strobes[b].data & EN_KEEP;
      end
    end

    assign stsFlat[b*REG_W +: REG_W] = stsQ;
    assign enFlat[b*REG_W +: REG_W]  = enQ;
    assign sumVec[b]                 = sumQ;
    assign rxRestart[b]              = restartQ;
  end
endmodule

// File: rtl/irqhub_top.sv
module irqhub_top
  import irqhub_pkg::*;
#(
  parameter int NBUS  = 16,
  parameter int BUS_W = (NBUS > 1) ? $clog2(NBUS) : 1,
  parameter int RD_W  = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NBUS*16-1:0]    evtIn,
  input  logic [NBUS-1:0]       rxCmdPending,
  input  logic                  wrEn,
  input  logic [1:0]            wrSel,
  input  logic [BUS_W-1:0]      wrBus,
  input  logic [15:0]           wrData,
  input  logic [1:0]            rdSel,
  input  logic [BUS_W-1:0]      rdBus,
  output logic [RD_W-1:0]       rdData,
  output logic [NBUS-1:0]       irq,
  output logic [NBUS-1:0]       rxRestart
);
  busStrobe_t [NBUS-1:0]  strobes;
  logic [NBUS*REG_W-1:0]  stsFlat;
  logic [NBUS*REG_W-1:0]  enFlat;
  logic [NBUS-1:0]        sumVec;

  irqhub_ctrl #(.NBUS(NBUS), .BUS_W(BUS_W), .RD_W(RD_W)) u_ctrl (
    .wrEn(wrEn), .wrSel(wrSel), .wrBus(wrBus), .wrData(wrData),
    .rdSel(rdSel), .rdBus(rdBus), .stsFlat(stsFlat), .enFlat(enFlat),
    .sumVec(sumVec), .strobes(strobes), .rdData(rdData)
  );

  irqhub_bank #(.NBUS(NBUS)) u_bank (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .rxCmdPending(rxCmdPending),
    .strobes(strobes), .stsFlat(stsFlat), .enFlat(enFlat),
    .sumVec(sumVec), .rxRestart(rxRestart)
  );

  assign irq = sumVec;
endmodule

// File: rtl/irqhub_chk.sv
module irqhub_chk
  import irqhub_pkg::*;
#(
  parameter int NBUS  = 16,
  parameter int BUS_W = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [NBUS*16-1:0]    evtIn,
  input logic [NBUS-1:0]       rxCmdPending,
  input logic                  wrEn,
  input logic [1:0]            wrSel,
  input logic [BUS_W-1:0]      wrBus,
  input logic [15:0]           wrData,
  input logic [NBUS-1:0]       irq,
  input logic [NBUS-1:0]       rxRestart,
  input logic [NBUS*16-1:0]    stsFlat,
  input logic [NBUS*16-1:0]    enFlat
);
  // R11: a write to a missing bus leaves every mask untouched
  a_r11_oob_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (int'(wrBus) >= NBUS)) |=> $stable(enFlat));

  for (genvar b = 0; b < NBUS; b++) begin : g_b
    // R5: the line only rises with something latched
    a_r5_rise_has_status: assert property (@(posedge clk) disable iff (!rstN)
      $rose(irq[b]) |-> (stsFlat[b*16 +: 16] != '0));
    // R7: the line only falls after a status write to this bus
    a_r7_fall_after_clear: assert property (@(posedge clk) disable iff (!rstN)
      $fell(irq[b]) |-> $past(wrEn && (wrSel == SEL_STATUS) && (wrBus == BUS_W'(b))));
    // R9: a restart pulse is caused by a receive-done clear with a pending command
    a_r9_restart_cause: assert property (@(posedge clk) disable iff (!rstN)
      rxRestart[b] |-> $past(wrEn && (wrSel == SEL_STATUS) && (wrBus == BUS_W'(b))
                             && wrData[RXDONE_BIT] && rxCmdPending[b]));
    // R3: bit 15 never latches
    a_r3_no_top_bit: assert property (@(posedge clk) disable iff (!rstN)
      !stsFlat[b*16 + 15]);
    for (genvar k = 0; k < 16; k++) begin : g_k
      if (EVT_VALID[k]) begin : g_v
        // R3 / R8: an enabled event is present next cycle
        a_r3_enabled_latches: assert property (@(posedge clk) disable iff (!rstN)
          (evtIn[b*16 + k] && enFlat[b*16 + k]) |=> stsFlat[b*16 + k]);
      end
    end
  end
endmodule

bind irqhub_top irqhub_chk #(.NBUS(NBUS), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rstN(rstN), .evtIn(evtIn), .rxCmdPending(rxCmdPending),
  .wrEn(wrEn), .wrSel(wrSel), .wrBus(wrBus), .wrData(wrData),
  .irq(irq), .rxRestart(rxRestart), .stsFlat(stsFlat), .enFlat(enFlat)
);

// File: tb/irqhub_top_tb.sv
`timescale 1ns/100ps
module irqhub_top_tb;
  localparam int NB = 5;
  localparam int BW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NB*16-1:0] evtIn = '0;
  logic [NB-1:0] rxPend = '0;
  logic wrEn = 1'b0;
  logic [1:0] wrSel = '0;
  logic [BW-1:0] wrBus = '0;
  logic [15:0] wrData = '0;
  logic [1:0] rdSel = '0;
  logic [BW-1:0] rdBus = '0;
  logic [31:0] rdData;
  logic [NB-1:0] irq, rxRestart;

  always #5 clk = ~clk;

  irqhub_top #(.NBUS(NB), .BUS_W(BW)) u_dut (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .rxCmdPending(rxPend),
    .wrEn(wrEn), .wrSel(wrSel), .wrBus(wrBus), .wrData(wrData),
    .rdSel(rdSel), .rdBus(rdBus), .rdData(rdData), .irq(irq), .rxRestart(rxRestart)
  );

  // behavioural reference model
  logic [15:0] mSts [NB];
  logic [15:0] mEn  [NB];
  bit          mSum [NB];
  bit          mRst [NB];

  function automatic bit isEventPos(int k);
    return (k <= 6) || (k >= 13);
  endfunction

  always @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (!rstN) begin
        mSts[b] <= '0; mEn[b] <= '0; mSum[b] <= 0; mRst[b] <= 0;
      end else begin
        logic [15:0] s;
        bit raised, hit, stsW, enW;
        s = mSts[b];
        stsW = wrEn && (int'(wrBus) == b) && (wrSel == 2'd1);
        enW  = wrEn && (int'(wrBus) == b) && (wrSel == 2'd0);
        hit  = stsW && wrData[2] && mSts[b][2] && rxPend[b];
        raised = hit;
        if (stsW) for (int k = 0; k < 15; k++) if (wrData[k]) s[k] = 1'b0;
        for (int k = 0; k < 16; k++)
          if (isEventPos(k) && evtIn[b*16+k]) begin s[k] = 1'b1; raised = 1; end
        if (raised) for (int k = 0; k < 16; k++) if (!mEn[b][k]) s[k] = 1'b0;
        mSts[b] <= s;
        if (raised && s != 0) mSum[b] <= 1;
        else if (stsW && s == 0) mSum[b] <= 0;
        mRst[b] <= hit;
        if (enW) mEn[b] <= {1'b0, wrData[14:0]};
      end
    end
  end

  int checks = 0, fails = 0;
  bit finished = 0;
  string curReq = "R1";

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(int sel, int bus);
    logic [31:0] v = '0;
    if (sel == 2) begin
      for (int b = 0; b < NB; b++) v[b] = mSum[b];
    end else if (bus < NB) begin
      if (sel == 0) v = {16'h0, mEn[bus]};
      else if (sel == 1) v = {16'h0, mSts[bus]};
    end
    return v;
  endfunction

  task automatic compareAll();
    logic [NB-1:0] eIrq, eRst;
    for (int b = 0; b < NB; b++) begin eIrq[b] = mSum[b]; eRst[b] = mRst[b]; end
    check(curReq, "irq", 32'(irq), 32'(eIrq));
    check(curReq, "rxRestart", 32'(rxRestart), 32'(eRst));
    for (int sel = 0; sel < 4; sel++)
      for (int bus = 0; bus <= NB; bus++) begin
        rdSel = 2'(sel); rdBus = BW'(bus); #0.1;
        check(curReq, $sformatf("read sel%0d bus%0d", sel, bus), rdData, expRead(sel, bus));
      end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
    compareAll();
    evtIn = '0; wrEn = 1'b0;
  endtask

  task automatic wr(int sel, int bus, logic [15:0] d);
    wrEn = 1'b1; wrSel = 2'(sel); wrBus = BW'(bus); wrData = d;
  endtask

  task automatic ev(int bus, logic [15:0] bits);
    evtIn[bus*16 +: 16] = bits;
  endtask

  task automatic readNow(int sel, int bus);
    rdSel = 2'(sel); rdBus = BW'(bus); #0.1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    curReq = "R1";
    compareAll();
    check("R1", "irq after reset", 32'(irq), 0);

    curReq = "R2";
    wr(0, 0, 16'hFFFF); step();
    readNow(0, 0); check("R2", "enable keeps 14:0", rdData, 32'h7FFF);
    wr(0, 1, 16'h0005); step();
    wr(0, 2, 16'h7FFF); step();

    curReq = "R3";
    ev(0, 16'h0005); ev(1, 16'h0002); ev(2, 16'h1F80); step();
    readNow(1, 0); check("R3", "enabled bits latch", rdData, 32'h0005);
    readNow(1, 1); check("R3", "disabled bit dropped", rdData, 32'h0);
    readNow(1, 2); check("R3", "reserved positions ignored", rdData, 32'h0);
    check("R5", "irq bus0 up, bus1/2 low", 32'(irq), 32'h1);
    ev(0, 16'h8000); step();
    readNow(1, 0); check("R3", "bit 15 never latches", rdData, 32'h0005);

    curReq = "R6";
    wr(1, 0, 16'h0001); step();
    readNow(1, 0); check("R6", "partial clear", rdData, 32'h0004);
    check("R7", "irq stays while bits remain", 32'(irq), 32'h1);
    curReq = "R7";
    wr(1, 0, 16'hFFFF); step();
    check("R7", "irq falls on empty status", 32'(irq), 32'h0);

    curReq = "R8";
    ev(0, 16'h0010); step();
    wr(1, 0, 16'h0010); ev(0, 16'h0010); step();
    readNow(1, 0); check("R8", "set wins over clear", rdData, 32'h0010);
    wr(1, 0, 16'h0010); step();

    curReq = "R4";
    wr(0, 3, 16'hFFFF); step();
    ev(3, 16'h0009); step();
    wr(0, 3, 16'h0008); step();
    readNow(1, 3); check("R4", "mask change alone keeps bits", rdData, 32'h0009);
    ev(3, 16'h0008); step();
    readNow(1, 3); check("R4", "raise drops disabled bit", rdData, 32'h0008);
    wr(0, 3, 16'h0000); step();
    ev(3, 16'h0002); step();
    readNow(1, 3); check("R4", "raise empties status", rdData, 32'h0);
    check("R7", "line kept when raise empties", 32'(irq[3]), 32'h1);
    wr(1, 3, 16'h0000); step();
    check("R7", "empty write drops line", 32'(irq[3]), 32'h0);

    curReq = "R9";
    rxPend[0] = 1'b1;
    ev(0, 16'h0004); step();
    wr(1, 0, 16'h0004); step();
    check("R9", "restart pulse", 32'(rxRestart), 32'h1);
    step();
    check("R9", "restart single cycle", 32'(rxRestart), 32'h0);
    ev(0, 16'h0004); step();
    rxPend[0] = 1'b0;
    wr(1, 0, 16'h0004); step();
    check("R9", "no restart without pending", 32'(rxRestart), 32'h0);
    rxPend[0] = 1'b1;
    wr(1, 0, 16'h0004); step();
    check("R9", "no restart when bit clear", 32'(rxRestart), 32'h0);
    ev(0, 16'h0005); step();
    wr(0, 0, 16'h0004); step();
    wr(1, 0, 16'h0004); step();
    check("R9", "restart with remask", 32'(rxRestart), 32'h1);
    readNow(1, 0); check("R9", "remask drops bit 0", rdData, 32'h0);
    rxPend[0] = 1'b0;

    curReq = "R10";
    ev(4, 16'h0000); wr(0, 4, 16'h0040); step();
    ev(4, 16'h0040); step();
    wr(2, 4, 16'h0000); step();
    readNow(2, 0); check("R10", "summary unchanged by write", rdData, 32'h10);
    wr(3, 4, 16'hFFFF); step();
    readNow(1, 4); check("R10", "selector 3 write no effect", rdData, 32'h0040);
    readNow(3, 4); check("R10", "selector 3 reads zero", rdData, 32'h0);

    curReq = "R11";
    for (int bus = NB; bus < 8; bus++) begin wr(0, bus, 16'hFFFF); step(); wr(1, bus, 16'hFFFF); step(); end
    readNow(1, 4); check("R11", "missing-bus clear ignored", rdData, 32'h0040);
    readNow(0, 5); check("R11", "missing-bus read zero", rdData, 32'h0);

    curReq = "R12";
    for (int i = 0; i < 400; i++) begin
      for (int b = 0; b < NB; b++) ev(b, 16'($urandom) & (($urandom % 3 == 0) ? 16'hFFFF : 16'h0));
      rxPend = NB'($urandom);
      if ($urandom % 2 == 0) wr(int'($urandom % 4), int'($urandom % 8), 16'($urandom));
      step();
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule